// File: doc/BRIEF.md
# General-Purpose IO Port with Peripheral Routing

This block is the programmable controller behind one bank of chip pads, with up to 16 pins in a bank. Software programs it through a small word-addressed register bus, and every access carries a secure or non-secure attribute. From those registers the block produces the complete set of pad controls for each pin: drive value, drive enable, open-drain select, pull-up and pull-down enables, input-buffer enable and a 2-bit slew code. It also connects each pin to one of 16 internal peripheral lines, in both directions.

Each pin works in one of four modes: software input, software output, peripheral-routed, or analog. Analog is the reset mode, and in it the pad is completely idle. A pin can be marked as owned by the secure side. Non-secure accesses then see zeros in that pin's fields, cannot change them, and raise a one-cycle error pulse if they try. Pad input is resynchronised before software or any peripheral sees it. A write-only set/clear word lets several masters change their own output bits without a read-modify-write.

The bus is one cycle per access with no stall. A write takes effect at the clock edge that samples it. Read data and the error pulse appear in the cycle after the access.

Top module: `gpio_port`

## Requirements
- R1: After reset, every implemented pin is in analog mode (mode code 11), so MODE (word 0) reads 11 in each implemented pin field. While a pin is in analog mode, its drive enable, input-buffer enable, pull-up and pull-down are all 0.
- R2: Mode codes are 00 input, 01 output, 10 peripheral-routed and 11 analog, in 2-bit fields at bits [2p+1:2p]. The input buffer is enabled in every mode except analog. INDATA (word 4) reads 0 for any pin in analog mode.
- R3: In output mode with push-pull type, the pad drive value is the pin's bit in OUTDATA (word 5), and the drive enable is 1.
- R4: Output type is set in OTYPE (word 1, bit p), where 1 means open-drain. An open-drain pin in output or peripheral-routed mode has its open-drain flag at 1. Its drive enable is 1 only while the driven value is 0.
- R5: Pull codes sit in PULL (word 3) as 2-bit fields: 01 pull-up, 10 pull-down, 00 or 11 none. The pulls are forced off in analog mode. Pull-up and pull-down are never both on.
- R6: The 2-bit code from SPEED (word 2) reaches the pad only in output or peripheral-routed mode. In any other mode the pad sees 00.
- R7: In peripheral-routed mode, a 4-bit selector picks line k of the pin's 16 lines. Pins 0–7 take their selector from AFLO (word 7) and pins 8–15 from AFHI (word 8), in nibble p mod 8. The drive value and drive enable come from peripheral line p*16+k. The synchronised pad input is returned only on peripheral input p*16+k, and every other line of that pin reads 0.
- R8: SETCLR (word 6) is write-only and reads 0. Bits [15:0] set output bits and bits [31:16] clear them. If one write both sets and clears the same pin, the set wins.
- R9: SECMASK (word 9) bit p marks pin p as secure, and only a secure write can change SECMASK. A non-secure read returns 0 in secure pins' fields. A non-secure write is dropped for secure pins' fields. Any non-zero bit that such a write places in a secure pin's field, any non-zero set or clear bit for a secure pin, and any non-secure write to SECMASK raises bus_err for exactly one cycle.
- R10: Fields of pins at index NPINS and above read 0 and ignore writes.
- R11: Pad input passes through two flops before INDATA. A read issued one cycle after a pad change still returns the old value, and the next read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_secure | input | 1 | Access attribute, 1 = secure |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after a refused non-secure write |
| pad_in | input | NPINS | Pad receive values |
| pad_out | output | NPINS | Pad drive values |
| pad_oe | output | NPINS | Pad drive enables |
| pad_od | output | NPINS | Open-drain select |
| pad_pu | output | NPINS | Pull-up enables |
| pad_pd | output | NPINS | Pull-down enables |
| pad_ie | output | NPINS | Input-buffer enables |
| pad_speed | output | 2*NPINS | Slew codes, 2 bits per pin |
| periph_out | input | 16*NPINS | Peripheral drive values, pin p line k at p*16+k |
| periph_oe | input | 16*NPINS | Peripheral drive enables, same indexing |
| periph_in | output | 16*NPINS | Synchronised pad input returned to the selected line |

## Verification
A corrupted mode field shows up at once on the pad controls in the same cycle, because every pad output is combinational from the stored fields. An analog pin that is driving or pulling, or an open-drain pin that is driving a 1, is flagged on the very edge where it happens. A wrong ownership mask shows up as non-zero read data or a missing error pulse one cycle after a non-secure access. A wrong output bit shows on pad_out right after the write that caused it. A synchroniser of the wrong depth shifts the first read that returns new pad data by one access.

// File: rtl/gpio_pkg.sv
// Shared types and register word indices for the IO port.
// Assumes at most 16 pins per bank.
package gpio_pkg;
    localparam int MAXP = 16;

    typedef enum logic [1:0] {
        MD_IN  = 2'b00,
        MD_OUT = 2'b01,
        MD_ALT = 2'b10,
        MD_ANA = 2'b11
    } pin_mode_e;

    localparam logic [3:0] A_MODE   = 4'd0;
    localparam logic [3:0] A_OTYPE  = 4'd1;
    localparam logic [3:0] A_SPEED  = 4'd2;
    localparam logic [3:0] A_PULL   = 4'd3;
    localparam logic [3:0] A_INDATA = 4'd4;
    localparam logic [3:0] A_OUTDAT = 4'd5;
    localparam logic [3:0] A_SETCLR = 4'd6;
    localparam logic [3:0] A_AFLO   = 4'd7;
    localparam logic [3:0] A_AFHI   = 4'd8;
    localparam logic [3:0] A_SECM   = 4'd9;

    // Widen a per-pin mask to a 2-bit-per-pin field mask.
    function automatic logic [31:0] pin2(input logic [15:0] m);
        logic [31:0] r;
        for (int i = 0; i < 16; i++) r[2*i +: 2] = {2{m[i]}};
        return r;
    endfunction

    // Nibble mask for pins 0..7.
    function automatic logic [31:0] lo4(input logic [15:0] m);
        logic [31:0] r;
        for (int i = 0; i < 8; i++) r[4*i +: 4] = {4{m[i]}};
        return r;
    endfunction

    // Nibble mask for pins 8..15.
    function automatic logic [31:0] hi4(input logic [15:0] m);
        logic [31:0] r;
        for (int i = 0; i < 8; i++) r[4*i +: 4] = {4{m[i+8]}};
        return r;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Shift pad values through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
// Register file of the IO port, with per-pin secure ownership filtering.
// Assumes single-cycle accesses; read data and the error flag are registered.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic        write,
    input  logic        secure,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    input  logic [15:0] indata,
    output logic [31:0] rdata,
    output logic        err,
    output logic [31:0] mode_q,
    output logic [15:0] otype_q,
    output logic [31:0] speed_q,
    output logic [31:0] pull_q,
    output logic [15:0] odata_q,
    output logic [63:0] af_q
);
    localparam logic [31:0] IMPL32 = (32'h1 << NPINS) - 32'h1;
    localparam logic [15:0] IMPL   = IMPL32[15:0];

    logic [15:0] sec_q;
    logic [15:0] own1, deny1;
    logic [31:0] own2, deny2;
    logic        wr, rd, deny_hit;
    logic [31:0] rd_mux;

    // Work out which pin fields this access may touch.
    always_comb begin
        own1  = secure ? IMPL : (IMPL & ~sec_q);
        deny1 = secure ? 16'h0 : (IMPL & sec_q);
        own2  = pin2(own1);
        deny2 = pin2(deny1);
        wr    = valid & write;
        rd    = valid & ~write;
    end

    // Detect a non-secure write reaching secure-owned fields.
    always_comb begin
        case (addr)
            A_MODE, A_SPEED, A_PULL: deny_hit = |(wdata & deny2);
            A_OTYPE, A_OUTDAT:       deny_hit = |(wdata[15:0] & deny1);
            A_SETCLR:                deny_hit = |((wdata[15:0] | wdata[31:16]) & deny1);
            A_AFLO:                  deny_hit = |(wdata & lo4(deny1));
            A_AFHI:                  deny_hit = |(wdata & hi4(deny1));
            A_SECM:                  deny_hit = ~secure;
            default:                 deny_hit = 1'b0;
        endcase
    end

    // Update configuration fields with owner-masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= pin2(IMPL);
            otype_q <= '0;
            speed_q <= '0;
            pull_q  <= '0;
            odata_q <= '0;
            af_q    <= '0;
            sec_q   <= '0;
        end else if (wr) begin
            case (addr)
                A_MODE:   mode_q  <= (mode_q & ~own2) | (wdata & own2);
                A_OTYPE:  otype_q <= (otype_q & ~own1) | (wdata[15:0] & own1);
                A_SPEED:  speed_q <= (speed_q & ~own2) | (wdata & own2);
                A_PULL:   pull_q  <= (pull_q & ~own2) | (wdata & own2);
                A_OUTDAT: odata_q <= (odata_q & ~own1) | (wdata[15:0] & own1);
                A_SETCLR: odata_q <= (odata_q & ~(wdata[31:16] & own1)) | (wdata[15:0] & own1);
                A_AFLO:   af_q[31:0]  <= (af_q[31:0] & ~lo4(own1)) | (wdata & lo4(own1));
                A_AFHI:   af_q[63:32] <= (af_q[63:32] & ~hi4(own1)) | (wdata & hi4(own1));
                A_SECM:   if (secure) sec_q <= wdata[15:0] & IMPL;
                default:  ;
            endcase
        end
    end

    // Select read data, hiding fields the requester does not own.
    always_comb begin
        case (addr)
            A_MODE:   rd_mux = mode_q & own2;
            A_OTYPE:  rd_mux = {16'h0, otype_q & own1};
            A_SPEED:  rd_mux = speed_q & own2;
            A_PULL:   rd_mux = pull_q & own2;
            A_INDATA: rd_mux = {16'h0, indata & own1};
            A_OUTDAT: rd_mux = {16'h0, odata_q & own1};
            A_AFLO:   rd_mux = af_q[31:0] & lo4(own1);
            A_AFHI:   rd_mux = af_q[63:32] & hi4(own1);
            A_SECM:   rd_mux = {16'h0, sec_q};
            default:  rd_mux = '0;
        endcase
    end

    // Register read data and the one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            if (rd) rdata <= rd_mux;
            err <= wr & deny_hit;
        end
    end
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-pin pad control and peripheral routing, purely combinational.
// Assumes sync_in is already synchronised to clk.
module gpio_pin_mux
    import gpio_pkg::*;
(
    input  logic [1:0]  mode,
    input  logic        otype,
    input  logic [1:0]  speed,
    input  logic [1:0]  pull,
    input  logic        odata,
    input  logic [3:0]  af_sel,
    input  logic [15:0] af_do,
    input  logic [15:0] af_oe,
    input  logic        sync_in,
    output logic        pad_out,
    output logic        pad_oe,
    output logic        pad_od,
    output logic        pad_pu,
    output logic        pad_pd,
    output logic        pad_ie,
    output logic [1:0]  pad_speed,
    output logic        idata,
    output logic [15:0] af_di
);
    pin_mode_e md;
    logic      drv_val, drv_en, active, digital;

    // Derive pad controls and returned input from the pin mode.
    always_comb begin
        md      = pin_mode_e'(mode);
        drv_val = 1'b0;
        drv_en  = 1'b0;
        case (md)
            MD_OUT: begin drv_val = odata;          drv_en = 1'b1;          end
            MD_ALT: begin drv_val = af_do[af_sel];  drv_en = af_oe[af_sel]; end
            default: ;
        endcase
        active    = (md == MD_OUT) || (md == MD_ALT);
        digital   = (md != MD_ANA);
        pad_out   = drv_val;
        pad_oe    = otype ? (drv_en & ~drv_val) : drv_en;
        pad_od    = active & otype;
        pad_ie    = digital;
        pad_pu    = digital & (pull == 2'b01);
        pad_pd    = digital & (pull == 2'b10);
        pad_speed = active ? speed : 2'b00;
        idata     = digital & sync_in;
        af_di     = (md == MD_ALT) ? ((16'h1 << af_sel) & {16{sync_in}}) : 16'h0;
    end
endmodule

// File: rtl/gpio_port.sv
// IO port top: register file, input synchroniser and one mux per pin.
// Assumes 1 <= NPINS <= 16; pins at NPINS and above are not built.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic                 bus_secure,
    input  logic [3:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_err,
    input  logic [NPINS-1:0]     pad_in,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pad_od,
    output logic [NPINS-1:0]     pad_pu,
    output logic [NPINS-1:0]     pad_pd,
    output logic [NPINS-1:0]     pad_ie,
    output logic [2*NPINS-1:0]   pad_speed,
    input  logic [16*NPINS-1:0]  periph_out,
    input  logic [16*NPINS-1:0]  periph_oe,
    output logic [16*NPINS-1:0]  periph_in
);
    logic [15:0] pad_full, sync_w, idata_w, otype_w, odata_w;
    logic [31:0] mode_w, speed_w, pull_w;
    logic [63:0] af_w;

    // Zero-extend the pad inputs to the full bank width.
    always_comb begin
        pad_full = '0;
        pad_full[NPINS-1:0] = pad_in;
    end

    gpio_sync #(.W(MAXP)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_full), .q(sync_w)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .valid(bus_valid), .write(bus_write),
        .secure(bus_secure), .addr(bus_addr), .wdata(bus_wdata),
        .indata(idata_w), .rdata(bus_rdata), .err(bus_err),
        .mode_q(mode_w), .otype_q(otype_w), .speed_q(speed_w),
        .pull_q(pull_w), .odata_q(odata_w), .af_q(af_w)
    );

    for (genvar p = 0; p < MAXP; p++) begin : g_pin
        if (p < NPINS) begin : g_on
            gpio_pin_mux u_mux (
                .mode(mode_w[2*p +: 2]), .otype(otype_w[p]),
                .speed(speed_w[2*p +: 2]), .pull(pull_w[2*p +: 2]),
                .odata(odata_w[p]), .af_sel(af_w[4*p +: 4]),
                .af_do(periph_out[16*p +: 16]), .af_oe(periph_oe[16*p +: 16]),
                .sync_in(sync_w[p]),
                .pad_out(pad_out[p]), .pad_oe(pad_oe[p]), .pad_od(pad_od[p]),
                .pad_pu(pad_pu[p]), .pad_pd(pad_pd[p]), .pad_ie(pad_ie[p]),
                .pad_speed(pad_speed[2*p +: 2]), .idata(idata_w[p]),
                .af_di(periph_in[16*p +: 16])
            );
        end else begin : g_off
            assign idata_w[p] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
// Property checker for gpio_port, attached by bind.
// Assumes it observes the port pins and the stored mode and output fields.
module gpio_port_chk #(
    parameter int NPINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_secure,
    input logic [3:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_err,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_od,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pad_pd,
    input logic [NPINS-1:0]  pad_ie,
    input logic [31:0]       mode_w,
    input logic [15:0]       odata_w
);
    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_valid && bus_write && !bus_secure));

    for (genvar p = 0; p < NPINS; p++) begin : g_p
        // R1
        analog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_w[2*p +: 2] == 2'b11) |-> (!pad_oe[p] && !pad_ie[p] && !pad_pu[p] && !pad_pd[p]));
        // R5
        pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[p] && pad_pd[p]));
        // R4
        od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_od[p] && pad_oe[p]) |-> !pad_out[p]);
        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_write && bus_secure && bus_addr == 4'd6 && bus_wdata[p])
            |=> odata_w[p]);
        // R8
        clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_write && bus_secure && bus_addr == 4'd6 && bus_wdata[16+p] && !bus_wdata[p])
            |=> !odata_w[p]);
    end
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_secure(bus_secure), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_err(bus_err), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie),
    .mode_w(mode_w), .odata_w(odata_w)
);

// File: tb/tb_gpio_port.sv
// Directed bench for gpio_port: one task per scenario.
module tb_gpio_port;
    localparam int N  = 16;
    localparam int NN = 12;
    localparam logic [3:0] W_MODE = 0, W_OTYPE = 1, W_SPEED = 2, W_PULL = 3,
                           W_IN = 4, W_OUT = 5, W_SC = 6, W_AFLO = 7, W_AFHI = 8, W_SEC = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid = 1'b0, write = 1'b0, sec = 1'b1;
    logic [3:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_n;
    logic err, err_n;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd, pad_ie;
    logic [2*N-1:0] pad_speed;
    logic [16*N-1:0] periph_out = '0, periph_oe = '0, periph_in;
    logic [NN-1:0] n_out, n_oe, n_od, n_pu, n_pd, n_ie;
    logic [2*NN-1:0] n_speed;
    logic [16*NN-1:0] n_pin;

    int checks = 0, errors = 0;
    logic [31:0] rd_v, rd_vn;
    logic err_v;

    always #5 clk = ~clk;

    gpio_port #(.NPINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(valid), .bus_write(write), .bus_secure(sec),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie), .pad_speed(pad_speed),
        .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in)
    );

    gpio_port #(.NPINS(NN)) dut_n (
        .clk(clk), .rst_n(rst_n), .bus_valid(valid), .bus_write(write), .bus_secure(sec),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_n), .bus_err(err_n),
        .pad_in('0), .pad_out(n_out), .pad_oe(n_oe), .pad_od(n_od),
        .pad_pu(n_pu), .pad_pd(n_pd), .pad_ie(n_ie), .pad_speed(n_speed),
        .periph_out('0), .periph_oe('0), .periph_in(n_pin)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; addr = a; wdata = d; sec = s;
        @(negedge clk);
        valid = 1'b0; write = 1'b0; sec = 1'b1;
        err_v = err;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic s);
        @(negedge clk);
        valid = 1'b1; write = 1'b0; addr = a; sec = s;
        @(negedge clk);
        valid = 1'b0; sec = 1'b1;
        rd_v = rdata; rd_vn = rdata_n;
    endtask

    task automatic t_reset();
        pad_in = '1;
        repeat (4) @(negedge clk);
        check("R1 pad_oe idle", 32'(pad_oe), 32'h0);
        check("R1 pad_ie idle", 32'(pad_ie), 32'h0);
        check("R1 pulls idle", 32'(pad_pu | pad_pd), 32'h0);
        bus_rd(W_MODE, 1'b1);
        check("R1 mode reset", rd_v, 32'hFFFF_FFFF);
        check("R10 narrow mode reset", rd_vn, 32'h00FF_FFFF);
        bus_rd(W_IN, 1'b1);
        check("R2 analog input reads 0", rd_v, 32'h0);
        pad_in = '0;
    endtask

    task automatic t_output();
        bus_wr(W_MODE, 32'hFFFF_FF55, 1'b1);
        bus_wr(W_OUT, 32'h0000_0005, 1'b1);
        check("R3 drive value", 32'(pad_out[3:0]), 32'h5);
        check("R3 drive enable", 32'(pad_oe[3:0]), 32'hF);
        check("R2 ie in output", 32'(pad_ie[3:0]), 32'hF);
        bus_wr(W_SPEED, 32'h0000_03E4, 1'b1);
        check("R6 speed codes", 32'(pad_speed[7:0]), 32'hE4);
        check("R6 analog speed 00", 32'(pad_speed[9:8]), 32'h0);
    endtask

    task automatic t_opendrain();
        bus_wr(W_OTYPE, 32'h0000_0003, 1'b1);
        bus_wr(W_OUT, 32'h0000_0001, 1'b1);
        check("R4 od flag", 32'(pad_od[1:0]), 32'h3);
        check("R4 od enables", 32'(pad_oe[1:0]), 32'h2);
        bus_wr(W_OTYPE, 32'h0, 1'b1);
    endtask

    task automatic t_setclr();
        bus_wr(W_SC, 32'h0003_0002, 1'b1);
        bus_rd(W_OUT, 1'b1);
        check("R8 set wins", rd_v, 32'h0000_0002);
        bus_rd(W_SC, 1'b1);
        check("R8 write-only reads 0", rd_v, 32'h0);
    endtask

    task automatic t_pull();
        bus_wr(W_PULL, 32'h0000_0100, 1'b1);
        check("R5 analog pull forced off", 32'(pad_pu[4]), 32'h0);
        bus_wr(W_MODE, 32'hFFFF_FC55, 1'b1);
        check("R5 pull-up in input", 32'(pad_pu[4]), 32'h1);
        check("R2 ie in input", 32'(pad_ie[4]), 32'h1);
        check("R2 no drive in input", 32'(pad_oe[4]), 32'h0);
        bus_wr(W_PULL, 32'h0000_0200, 1'b1);
        check("R5 pull-down", {30'h0, pad_pu[4], pad_pd[4]}, 32'h1);
    endtask

    task automatic t_input();
        pad_in = 16'h0010;
        bus_rd(W_IN, 1'b1);
        check("R11 first read old", rd_v, 32'h0);
        bus_rd(W_IN, 1'b1);
        check("R11 second read new", rd_v, 32'h0000_0010);
    endtask

    task automatic t_alt();
        bus_wr(W_MODE, 32'hFFFB_FC55, 1'b1);
        bus_wr(W_AFHI, 32'h0000_0050, 1'b1);
        bus_wr(W_SPEED, 32'h0008_03E4, 1'b1);
        periph_out[9*16+5] = 1'b1; periph_oe[9*16+5] = 1'b1;
        periph_out[9*16+4] = 1'b0; periph_oe[9*16+4] = 1'b0;
        @(negedge clk);
        check("R7 routed drive", {30'h0, pad_out[9], pad_oe[9]}, 32'h3);
        check("R6 routed speed", 32'(pad_speed[19:18]), 32'h2);
        periph_oe[9*16+5] = 1'b0; periph_oe[9*16+4] = 1'b1;
        @(negedge clk);
        check("R7 direction from line", 32'(pad_oe[9]), 32'h0);
        pad_in[9] = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 input return", periph_in[9*16 +: 16], 32'h0000_0020);
    endtask

    task automatic t_secure();
        bus_wr(W_SEC, 32'h0000_0001, 1'b1);
        bus_wr(W_SC, 32'h0000_0001, 1'b1);
        check("R8 secure set", 32'(pad_out[0]), 32'h1);
        bus_rd(W_MODE, 1'b0);
        check("R9 ns read hides", rd_v, 32'hFFFB_FC54);
        bus_wr(W_SC, 32'h0001_0000, 1'b0);
        check("R9 ns err", 32'(err_v), 32'h1);
        check("R9 secure pin kept", 32'(pad_out[0]), 32'h1);
        @(negedge clk);
        check("R9 err one cycle", 32'(err), 32'h0);
        bus_wr(W_SC, 32'h0002_0000, 1'b0);
        check("R9 ns own pin no err", 32'(err_v), 32'h0);
        check("R9 ns clears own pin", 32'(pad_out[1]), 32'h0);
        bus_wr(W_SEC, 32'h0, 1'b0);
        check("R9 ns mask write err", 32'(err_v), 32'h1);
        bus_rd(W_SEC, 1'b1);
        check("R9 mask unchanged", rd_v, 32'h1);
    endtask

    task automatic t_narrow();
        bus_wr(W_OUT, 32'h0000_FFFF, 1'b1);
        bus_rd(W_OUT, 1'b1);
        check("R10 narrow outdata", rd_vn, 32'h0000_0FFF);
        bus_wr(W_AFHI, 32'hFFFF_FFFF, 1'b1);
        bus_rd(W_AFHI, 1'b1);
        check("R10 narrow af high", rd_vn, 32'h0000_FFFF);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_output();
        t_opendrain();
        t_setclr();
        t_pull();
        t_input();
        t_alt();
        t_secure();
        t_narrow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule